// File: doc/BRIEF.md
# Run-Time Clock Phase Stepper

This block sits in core logic and moves the phase of a PLL output counter while the PLL keeps running. A requester presents a target counter code, a direction and a number of steps. The block then performs the steps one at a time on the PLL's phase-adjust port. Each step moves the selected counter by one eighth of a VCO period. Everything runs on the free-running scan clock that the PLL also samples on its rising edge.

For every step, the block first drives the counter code and the direction. It raises the step strobe only after those values have been stable for at least one cycle and the PLL's completion line reads high. It holds the strobe until it sees completion go low, which means the PLL has taken the step. It then waits for completion to return high before it counts the step as finished. The completion line rises on the PLL's own timing, so it is brought through a synchronizer first. A per-step watchdog ends the sequence with an error flag if completion stops moving. The output clocks are never held in reset during any of this.

Top module: `phase_step_seq`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `busy`, `done`, `err` and `ps_step` are 0.
- R2: A request seen while idle (`busy`=0) is accepted on that clock edge. From the next cycle `busy` is 1 and `ps_sel`/`ps_dir` carry the request's code and direction. `ps_dir`=1 means shift later and 0 means shift earlier. Both stay unchanged until `busy` falls.
- R3: `ps_step` rises no earlier than one cycle after `busy` rises, and only while the synchronized completion reads high. With completion already high, it rises on the second edge after acceptance.
- R4: `ps_step` stays high until completion is seen low, then drops. The PLL therefore registers exactly one step per strobe.
- R5: The next step starts only after completion has returned high. A request for N steps (N≥1) makes the PLL register exactly N steps in the requested direction on the requested counter.
- R6: After the last step completes, `done` is high for exactly one cycle, and `busy` is 0 in that same cycle.
- R7: A request with a step count of 0 issues no strobe and gives the one-cycle `done` pulse on the edge that accepts it, with `busy` staying 0.
- R8: A request made while `busy` is 1 has no effect: the code, the direction and the number of steps performed stay those of the running request.
- R9: If one step does not finish within `WDOG_CYC` clock cycles, the sequence aborts. `busy` and `ps_step` go to 0, `err` goes to 1 and no `done` pulse occurs. `err` stays set until the next accepted request clears it on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running scan clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_sel | input | SEL_W | Counter code to adjust (any code is passed through, including the all-counters code) |
| req_dir | input | 1 | 1 = later, 0 = earlier |
| req_steps | input | STEP_W | Number of eighth-period steps |
| pll_done | input | 1 | PLL completion line (asynchronous rise) |
| ps_sel | output | SEL_W | Counter code to the PLL |
| ps_dir | output | 1 | Direction to the PLL |
| ps_step | output | 1 | Step strobe to the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when all steps have completed |
| err | output | 1 | Sticky watchdog abort flag |

## Verification
After an accepting edge, `busy` and the latched code and direction are due one edge later, and the first strobe is due on the second edge. A zero-step `done` appears on the accepting edge itself. The bench drives inputs on falling edges and samples on the next falling edge, so these exact latencies are checked cycle by cycle. For a step, completion passes through two synchronizer flops plus the modelled PLL delay, so the bench does not pin multi-step requests to a cycle. It waits for `busy` to fall and then compares the PLL model's tally of registered steps and net phase with the request. The watchdog abort is checked to land within `WDOG_CYC` plus a few cycles of the stall.

// File: rtl/ps_pkg.sv
package ps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ASSERT  = 2'd2,
    ST_RELEASE = 2'd3
  } ps_state_t;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ps_watchdog.sv
module ps_watchdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));
endmodule

// File: rtl/ps_step_ctr.sv
module ps_step_ctr #(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STEP_W-1:0] load_val,
  input  logic              dec,
  output logic              last
);
  logic [STEP_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst) remaining <= '0;
    else if (load) remaining <= load_val;
    else if (dec && remaining != '0) remaining <= remaining - 1'b1;
  end

  assign last = (remaining == STEP_W'(1));
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
  parameter int SEL_W       = 4,
  parameter int STEP_W      = 8,
  parameter int WDOG_CYC    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              req_dir,
  input  logic [STEP_W-1:0] req_steps,
  input  logic              pll_done,
  output logic [SEL_W-1:0]  ps_sel,
  output logic              ps_dir,
  output logic              ps_step,
  output logic              busy,
  output logic              done,
  output logic              err
);
  import ps_pkg::*;

  ps_state_t state;
  logic done_s;
  logic accept, zero_req, step_fin, last, wd_expired, wd_clear, active;

  ps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pll_done), .q(done_s)
  );

  assign active   = (state != ST_IDLE);
  assign accept   = req_valid && !active;
  assign zero_req = (req_steps == '0);
  assign step_fin = (state == ST_RELEASE) && done_s;
  assign wd_clear = !active || step_fin;

  ps_step_ctr #(.STEP_W(STEP_W)) u_ctr (
    .clk(clk), .rst(rst),
    .load(accept && !zero_req), .load_val(req_steps),
    .dec(step_fin), .last(last)
  );

  ps_watchdog #(.LIMIT(WDOG_CYC)) u_wdog (
    .clk(clk), .rst(rst), .clear(wd_clear), .run(active),
    .expired(wd_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ps_sel  <= '0;
      ps_dir  <= 1'b0;
      ps_step <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (active && wd_expired) begin
        state   <= ST_IDLE;
        ps_step <= 1'b0;
        busy    <= 1'b0;
        err     <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (accept) begin
              err <= 1'b0;
              if (zero_req) begin
                done <= 1'b1;
              end else begin
                ps_sel <= req_sel;
                ps_dir <= req_dir;
                busy   <= 1'b1;
                state  <= ST_SETUP;
              end
            end
          end
          ST_SETUP: begin
            if (done_s) begin
              ps_step <= 1'b1;
              state   <= ST_ASSERT;
            end
          end
          ST_ASSERT: begin
            if (!done_s) begin
              ps_step <= 1'b0;
              state   <= ST_RELEASE;
            end
          end
          ST_RELEASE: begin
            if (done_s) begin
              if (last) begin
                state <= ST_IDLE;
                busy  <= 1'b0;
                done  <= 1'b1;
              end else begin
                state <= ST_SETUP;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: code and direction held for the whole sequence
  p_sel_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(ps_sel) && $stable(ps_dir)));
  // R3: strobe only inside a sequence, set up one cycle ahead, completion high
  p_step_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    ps_step |-> busy);
  p_step_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ps_step) |-> ($past(busy) && $past(done_s)));
  // R4: strobe drops only after completion was seen low, or on abort
  p_step_release_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ps_step) |-> (!$past(done_s) || err));
  // R6: one-cycle done, never with busy
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: abort leaves the port quiet
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (!busy && !ps_step && !done));
endmodule

// File: tb/phase_step_seq_tb.sv
module phase_step_seq_tb;
  localparam int SEL_W = 4;
  localparam int STEP_W = 8;
  localparam int WDOG = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [SEL_W-1:0] req_sel = '0;
  logic req_dir = 1'b0;
  logic [STEP_W-1:0] req_steps = '0;
  logic pll_done;
  logic [SEL_W-1:0] ps_sel;
  logic ps_dir, ps_step, busy, done, err;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  phase_step_seq #(.SEL_W(SEL_W), .STEP_W(STEP_W), .WDOG_CYC(WDOG)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
    .req_dir(req_dir), .req_steps(req_steps), .pll_done(pll_done),
    .ps_sel(ps_sel), .ps_dir(ps_dir), .ps_step(ps_step),
    .busy(busy), .done(done), .err(err)
  );

  // PLL model: takes a step when strobe is high and completion high,
  // drops completion on that edge, raises it after delay_cfg cycles.
  int delay_cfg = 4;
  bit stuck = 1'b0;
  int dly = 0;
  int accepts = 0;
  int phase [16] = '{default: 0};

  always @(posedge clk) begin
    if (rst) begin
      pll_done <= 1'b1;
      dly <= 0;
    end else if (pll_done) begin
      if (ps_step) begin
        pll_done <= 1'b0;
        dly <= delay_cfg;
        accepts <= accepts + 1;
        phase[ps_sel] <= phase[ps_sel] + (ps_dir ? 1 : -1);
      end
    end else if (!stuck) begin
      if (dly <= 1) pll_done <= 1'b1;
      else dly <= dly - 1;
    end
  end

  int done_cnt = 0;
  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] s, input logic d, input logic [7:0] n);
    req_sel = s; req_dir = d; req_steps = n; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(input int limit, output int cyc);
    cyc = 0;
    while (busy && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // {sel[3:0], dir, steps[7:0], pll delay[3:0]}
  localparam logic [16:0] VEC [5] = '{
    {4'd3,  1'b1, 8'd3, 4'd4},
    {4'd15, 1'b0, 8'd2, 4'd6},
    {4'd10, 1'b1, 8'd1, 4'd9},
    {4'd0,  1'b0, 8'd5, 4'd5},
    {4'd7,  1'b1, 8'd4, 4'd7}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cyc, a0, d0, p0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 busy in reset", busy, 0);
    chk("R1 step in reset", ps_step, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 err after reset", err, 0);
    repeat (4) @(negedge clk);

    // R2/R3 exact latency
    delay_cfg = 4;
    a0 = accepts;
    issue(4'd6, 1'b1, 8'd1);
    chk("R2 busy one edge after accept", busy, 1);
    chk("R2 sel latched", ps_sel, 6);
    chk("R2 dir latched", ps_dir, 1);
    chk("R3 no strobe on first cycle", ps_step, 0);
    @(negedge clk);
    chk("R3 strobe on second edge", ps_step, 1);
    wait_idle(500, cyc);
    chk("R4 one step per strobe", accepts - a0, 1);
    repeat (5) @(negedge clk);

    // Vector table: R5 step count and direction, R6 single done
    foreach (VEC[i]) begin
      logic [3:0] s; logic d; logic [7:0] n;
      {s, d, n} = VEC[i][16:4];
      delay_cfg = int'(VEC[i][3:0]);
      a0 = accepts; d0 = done_cnt; p0 = phase[s];
      issue(s, d, n);
      wait_idle(5000, cyc);
      @(negedge clk);
      chk("R5 steps taken", accepts - a0, int'(n));
      chk("R5 net phase", phase[s] - p0, d ? int'(n) : -int'(n));
      chk("R6 one done cycle", done_cnt - d0, 1);
      chk("R6 busy low at end", busy, 0);
      chk("R9 no error", err, 0);
      repeat (3) @(negedge clk);
    end

    // R7 zero-step request
    a0 = accepts; d0 = done_cnt;
    issue(4'd2, 1'b0, 8'd0);
    chk("R7 done on accepting edge", done, 1);
    chk("R7 busy stays low", busy, 0);
    repeat (3) @(negedge clk);
    chk("R7 no strobe taken", accepts - a0, 0);
    chk("R7 single done", done_cnt - d0, 1);

    // R8 request while busy ignored
    delay_cfg = 5;
    a0 = accepts; p0 = phase[9];
    issue(4'd2, 1'b1, 8'd2);
    @(negedge clk);
    issue(4'd9, 1'b0, 8'd7);
    chk("R8 sel unchanged", ps_sel, 2);
    chk("R8 dir unchanged", ps_dir, 1);
    wait_idle(5000, cyc);
    repeat (3) @(negedge clk);
    chk("R8 step count of first request", accepts - a0, 2);
    chk("R8 other counter untouched", phase[9] - p0, 0);

    // R9 watchdog abort
    stuck = 1'b1;
    a0 = accepts; d0 = done_cnt;
    issue(4'd5, 1'b1, 8'd3);
    wait_idle(WDOG + 200, cyc);
    chk("R9 aborted within window", int'(cyc <= WDOG + 8), 1);
    chk("R9 err set", err, 1);
    chk("R9 strobe low", ps_step, 0);
    chk("R9 no done", done_cnt - d0, 0);
    chk("R9 one step taken before stall", accepts - a0, 1);
    repeat (10) @(negedge clk);
    chk("R9 err sticky", err, 1);
    stuck = 1'b0;
    repeat (20) @(negedge clk);
    issue(4'd5, 1'b0, 8'd1);
    chk("R9 err cleared by new request", err, 0);
    wait_idle(500, cyc);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule